// File: doc/BRIEF.md
# Single-Cycle Four-Instruction Processor Core

This block is a 32-bit processor core that completes every instruction in one clock. It runs four instructions: register-register add, word load, word store, and a conditional branch taken when two registers differ. In a single cycle the core fetches from a small internal instruction array and reads two registers. It then computes either a sum or a difference, optionally reads or writes a small internal data array, and at the rising edge commits the register write and the next program counter.

One combinational decoder looks at the opcode and the function field together. It produces every steering choice for the cycle:
- which field names the destination register;
- whether the second ALU operand is register data or the sign-extended immediate;
- whether the register write data comes from memory or from the ALU;
- whether the next PC is the sequential address or the branch target.

Both arrays are filled through a preload port while reset is held. Each committed register write and memory write appears on observation outputs, together with the current PC and instruction.

Top module: `onecycle_cpu`

## Requirements
- R1: A synchronous reset sets the PC to 0 and clears every register, so the first instruction after reset reads zeros.
- R2: An instruction with bits 31:26 = 0 and bits 5:0 = 32 writes the sum of register[25:21] and register[20:16] into register[15:11].
- R3: Opcode 35 (bits 31:26) writes into register[20:16] the data word at the address register[25:21] plus the sign-extended bits 15:0. Negative offsets are included.
- R4: Opcode 43 writes register[20:16] into the data word at the address register[25:21] plus the sign-extended bits 15:0. It makes no register write.
- R5: Opcode 5 with register[25:21] different from register[20:16] loads the PC with PC+4 plus the sign-extended bits 15:0 shifted left by 2. This holds for forward and backward offsets.
- R6: Opcode 5 with equal registers, and every add, load or store, sets the next PC to PC+4.
- R7: Register 0 always reads as zero. A write aimed at it is dropped, and no register write is reported on the outputs.
- R8: An opcode other than 0, 35, 43 or 5, or opcode 0 with a function code other than 32, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; preload writes are accepted only while it is high |
| ld_imem_we | input | 1 | Preload write strobe for the instruction array |
| ld_imem_addr | input | 6 | Word index into the instruction array |
| ld_dmem_we | input | 1 | Preload write strobe for the data array |
| ld_dmem_addr | input | 6 | Word index into the data array |
| ld_data | input | 32 | Preload write word for either array |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed this cycle |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Data of that write |
| dm_we_o | output | 1 | A data-array write commits at the next edge |
| dm_addr_o | output | 32 | Byte address of the data access (ALU result) |
| dm_wdata_o | output | 32 | Store data |

## Verification
The program starts with loads from preloaded words. An add follows that consumes the loaded values, which shows that a register result is available to the very next instruction. A load with a negative offset from a computed base checks sign extension, and that load reads back an earlier store, so the store address and the data path are both confirmed.

The branch is tried with equal registers, with a forward taken offset, and with a backward offset that forms a two-pass loop. Together these separate taken from not-taken and positive from negative target arithmetic. The program also includes:
- a write to register 0, followed by a read of it;
- an unknown function code;
- an unknown opcode;
- zero words after the program, which show the no-effect path.

A reset in the middle of the run shows that the PC and the registers clear while the data array keeps its contents.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;
    localparam logic [5:0] OPC_BRNE  = 6'd5;
    localparam logic [5:0] FUN_ADD   = 6'd32;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    wb_from_mem;
        logic    reg_wr;
        logic    mem_wr;
        logic    br_ne;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_REG: begin
                if (funct == FUN_ADD) begin
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.reg_wr    = 1'b1;
                end
            end
            OPC_LOAD: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            OPC_BRNE: begin
                ctrl.br_ne  = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        y    = (op == ALU_SUB) ? (a - b) : (a + b);
        zero = (y == '0);
    end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int XLEN   = 32,
    parameter int NREGS  = 32,
    parameter int NREAD  = 2,
    localparam int RAW   = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NREAD-1:0][RAW-1:0] raddr,
    output logic [NREAD-1:0][XLEN-1:0] rdata,
    input  logic                      we,
    input  logic [RAW-1:0]            waddr,
    input  logic [XLEN-1:0]           wdata
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) begin
                regs_d[i] = '0;
            end else if (we && (waddr == RAW'(i)) && (i != 0)) begin
                regs_d[i] = wdata;
            end else begin
                regs_d[i] = regs_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            regs_q[i] <= regs_d[i];
        end
    end

    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs_q[raddr[p]];
    end

endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
    import cpu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREGS      = 32,
    localparam int IAW       = $clog2(IMEM_WORDS),
    localparam int DAW       = $clog2(DMEM_WORDS),
    localparam int RAW       = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_imem_we,
    input  logic [IAW-1:0]  ld_imem_addr,
    input  logic            ld_dmem_we,
    input  logic [DAW-1:0]  ld_dmem_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] instr_o,
    output logic            rf_we_o,
    output logic [RAW-1:0]  rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            dm_we_o,
    output logic [XLEN-1:0] dm_addr_o,
    output logic [XLEN-1:0] dm_wdata_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    logic [XLEN-1:0]            instr;
    ctrl_t                      ctrl;
    logic [1:0][RAW-1:0]        rd_addr;
    logic [1:0][XLEN-1:0]       rd_data;
    logic [XLEN-1:0]            imm_ext;
    logic [XLEN-1:0]            alu_b;
    logic [XLEN-1:0]            alu_y;
    logic                       alu_zero;
    logic [RAW-1:0]             wr_reg;
    logic [XLEN-1:0]            wr_data;
    logic [XLEN-1:0]            mem_rdata;
    logic [XLEN-1:0]            pc_seq;
    logic [XLEN-1:0]            pc_br;
    logic                       br_taken;
    logic                       commit_reg;

    // Fetch and field split
    assign instr      = imem_q[st_q.pc[IAW+1:2]];
    assign rd_addr[0] = instr[25:21];
    assign rd_addr[1] = instr[20:16];
    assign imm_ext    = {{(XLEN-16){instr[15]}}, instr[15:0]};

    cpu_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    cpu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NREAD(2)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .raddr (rd_addr),
        .rdata (rd_data),
        .we    (commit_reg),
        .waddr (wr_reg),
        .wdata (wr_data)
    );

    cpu_alu #(.XLEN(XLEN)) u_alu (
        .a    (rd_data[0]),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Steering and next-state
    always_comb begin
        alu_b      = ctrl.b_is_imm ? imm_ext : rd_data[1];
        wr_reg     = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
        mem_rdata  = dmem_q[alu_y[DAW+1:2]];
        wr_data    = ctrl.wb_from_mem ? mem_rdata : alu_y;
        commit_reg = ctrl.reg_wr && (wr_reg != '0);
        pc_seq     = st_q.pc + XLEN'(4);
        pc_br      = pc_seq + (imm_ext << 2);
        br_taken   = ctrl.br_ne && !alu_zero;

        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = br_taken ? pc_br : pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Instruction array: preload only under reset
    always_ff @(posedge clk) begin
        if (rst && ld_imem_we) begin
            imem_q[ld_imem_addr] <= ld_data;
        end
    end

    // Data array: preload under reset, stores otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_dmem_we) begin
                dmem_q[ld_dmem_addr] <= ld_data;
            end
        end else if (ctrl.mem_wr) begin
            dmem_q[alu_y[DAW+1:2]] <= rd_data[1];
        end
    end

    assign pc_o       = st_q.pc;
    assign instr_o    = instr;
    assign rf_we_o    = commit_reg;
    assign rf_waddr_o = wr_reg;
    assign rf_wdata_o = wr_data;
    assign dm_we_o    = ctrl.mem_wr;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd_data[1];

endmodule

// File: rtl/onecycle_cpu_checker.sv
module onecycle_cpu_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr_o,
    input logic        rf_we_o,
    input logic [4:0]  rf_waddr_o,
    input logic        dm_we_o
);

    logic known_op;
    assign known_op = (instr_o[31:26] == 6'd0)  || (instr_o[31:26] == 6'd35) ||
                      (instr_o[31:26] == 6'd43) || (instr_o[31:26] == 6'd5);

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc_o == 32'd0));

    assert_load_dest_R3: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && instr_o[31:26] == 6'd35) |-> (rf_waddr_o == instr_o[20:16]));

    assert_store_only_R4: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> (instr_o[31:26] == 6'd43 && !rf_we_o));

    assert_seq_pc_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_o[31:26] != 6'd5) |=> (pc_o == $past(pc_o) + 32'd4));

    assert_no_r0_write_R7: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (rf_waddr_o != 5'd0));

    assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!known_op || (instr_o[31:26] == 6'd0 && instr_o[5:0] != 6'd32))
            |-> (!rf_we_o && !dm_we_o));

endmodule

bind onecycle_cpu onecycle_cpu_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .instr_o    (instr_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .dm_we_o    (dm_we_o)
);

// File: tb/onecycle_cpu_tb_top.sv
`timescale 1ns/1ps
module onecycle_cpu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0;
    logic [5:0]  ld_imem_addr = '0;
    logic        ld_dmem_we = 1'b0;
    logic [5:0]  ld_dmem_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    always #2.5 clk = ~clk;

    onecycle_cpu dut_i (
        .clk(clk), .rst(rst),
        .ld_imem_we(ld_imem_we), .ld_imem_addr(ld_imem_addr),
        .ld_dmem_we(ld_dmem_we), .ld_dmem_addr(ld_dmem_addr), .ld_data(ld_data),
        .pc_o(pc_o), .instr_o(instr_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] im   [64];
    logic [31:0] m_dm [64];
    logic [31:0] m_r  [32];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(logic [4:0] rd, logic [4:0] rs, logic [4:0] rt, logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 32'd0;
        for (int i = 0; i < 32; i++) m_r[i] = 32'd0;
    endtask

    // Compare one cycle at the falling edge, then advance the model.
    task automatic step();
        logic [31:0] ins, sx, val, addr, npc;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, dst;
        logic        e_rwe, e_mwe;
        string       tag, ptag;
        ins = im[m_pc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        sx = {{16{ins[15]}}, ins[15:0]};
        e_rwe = 1'b0; e_mwe = 1'b0; val = '0; addr = '0; dst = '0;
        npc = m_pc + 32'd4; ptag = "R6";
        if (op == 6'd0 && fn == 6'd32) begin
            dst = rd; val = m_r[rs] + m_r[rt]; e_rwe = (rd != 5'd0);
            tag = (rd == 5'd0) ? "R7" : ((m_pc == 32'd0) ? "R1" : "R2");
        end else if (op == 6'd35) begin
            addr = m_r[rs] + sx; dst = rt; val = m_dm[addr[7:2]]; e_rwe = (rt != 5'd0);
            tag = "R3";
        end else if (op == 6'd43) begin
            addr = m_r[rs] + sx; e_mwe = 1'b1; val = m_r[rt];
            tag = "R4";
        end else if (op == 6'd5) begin
            if (m_r[rs] != m_r[rt]) begin
                npc = m_pc + 32'd4 + (sx << 2); ptag = "R5"; tag = "R5";
            end else begin
                tag = "R6";
            end
        end else begin
            tag = "R8"; ptag = "R8";
        end
        check(tag, "instr", instr_o, ins);
        check(tag, "reg write enable", {31'd0, rf_we_o}, {31'd0, e_rwe});
        if (e_rwe) begin
            check(tag, "reg write addr", {27'd0, rf_waddr_o}, {27'd0, dst});
            check(tag, "reg write data", rf_wdata_o, val);
        end
        check(tag, "mem write enable", {31'd0, dm_we_o}, {31'd0, e_mwe});
        if (e_mwe) begin
            check(tag, "mem addr", dm_addr_o, addr);
            check(tag, "mem data", dm_wdata_o, val);
        end
        if (e_rwe) m_r[dst] = val;
        if (e_mwe) m_dm[addr[7:2]] = val;
        m_pc = npc;
        @(negedge clk);
        check(ptag, "pc", pc_o, m_pc);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            im[i]   = 32'd0;
            m_dm[i] = 32'(i * 3 + 100);
        end
        m_dm[0] = 32'd5;
        m_dm[1] = 32'd7;
        im[0]  = enc_r(5'd11, 5'd12, 5'd13, 6'd32);
        im[1]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
        im[2]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
        im[3]  = enc_r(5'd3, 5'd1, 5'd2, 6'd32);
        im[4]  = enc_i(6'd43, 5'd0, 5'd3, 16'd8);
        im[5]  = enc_r(5'd5, 5'd3, 5'd3, 6'd32);
        im[6]  = enc_i(6'd35, 5'd5, 5'd4, 16'hFFF0);
        im[7]  = enc_r(5'd0, 5'd1, 5'd2, 6'd32);
        im[8]  = enc_r(5'd6, 5'd0, 5'd1, 6'd32);
        im[9]  = enc_r(5'd7, 5'd1, 5'd2, 6'd34);
        im[10] = enc_i(6'd8, 5'd1, 5'd7, 16'd5);
        im[11] = enc_i(6'd5, 5'd1, 5'd1, 16'd5);
        im[12] = enc_i(6'd5, 5'd1, 5'd2, 16'd2);
        im[13] = enc_r(5'd8, 5'd1, 5'd1, 6'd32);
        im[14] = enc_r(5'd8, 5'd1, 5'd1, 6'd32);
        im[15] = enc_i(6'd43, 5'd5, 5'd6, 16'hFFFC);
        im[16] = enc_r(5'd10, 5'd1, 5'd1, 6'd32);
        im[17] = enc_r(5'd9, 5'd9, 5'd1, 6'd32);
        im[18] = enc_i(6'd5, 5'd9, 5'd10, 16'hFFFE);

        // Preload while reset is held
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b1; ld_imem_addr = 6'(i); ld_data = im[i];
        end
        ld_imem_we = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ld_dmem_we = 1'b1; ld_dmem_addr = 6'(i); ld_data = m_dm[i];
        end
        @(negedge clk);
        ld_dmem_we = 1'b0;
        @(negedge clk);
        check("R1", "pc after reset", pc_o, 32'd0);
        rst = 1'b0;
        model_reset();

        for (int c = 0; c < 60; c++) step();

        // Reset in mid-run: PC and registers clear, data array kept
        rst = 1'b1;
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc_o, 32'd0);
        rst = 1'b0;
        model_reset();
        for (int c = 0; c < 40; c++) step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule